// File: doc/BRIEF.md
# Staged Link Configuration Register Bank

This block is a byte-wide register file for the transport-layer settings of a serial converter link: device and bank identity, lane identity, lane count, scrambling enable, octets per frame, frames per multiframe, converter count, resolution, bits per sample, samples per frame, subclass and revision. Software reaches it through a single write port (address, byte, strobe) and a combinational read port.

Parameter writes never reach the link directly. Software first opens an update through the start register, which holds the link transmitter and its clock multiplier in reset. It then writes the parameter bytes into staged copies and writes the commit register. One cycle after the commit write, the staged values are copied into the active outputs, the hold is released and a one-cycle update pulse is issued. The start and commit bits clear by themselves.

During the copy, the block applies the product's limits. Lane count and resolution can only be lowered, never raised above the speed-grade ceilings set by parameter. The unsupported subclass code is refused. The control-bit, high-density and control-word fields are tied to zero.

Top module: `link_cfg_bank`

## Requirements
- R1: After reset, xmit_hold_o and cfg_upd_o are 0, lanes_o equals LANE_MAX, res_o equals RES_MAX, subcls_o is 0, frames_o is 15, dev_id_o is 0, and reads of 0xE3 and 0xE7 return LANE_MAX and RES_MAX in bits 4:0.
- R2: A write with data bit 0 set to address 0xDF opens an update. From the next cycle xmit_hold_o is 1, and a read of 0xDF returns bit 0 set.
- R3: While an update is open, writes to 0xE0..0xED change the staged bytes seen on the read port, and the active outputs keep their values until commit.
- R4: A write with bit 0 set to 0xEE during an open update takes effect in the next cycle. In that cycle the active outputs take the staged values, xmit_hold_o is 0, and cfg_upd_o is 1 for exactly one cycle. Afterwards reads of 0xDF and 0xEE return 0.
- R5: A commit write while no update is open is ignored: no pulse, no hold, and the active outputs are unchanged.
- R6: Writes to 0xE0..0xED while no update is open are ignored, and the read port still returns the previous byte.
- R7: The fixed-zero fields (0xE7[7:6], 0xEA[7], 0xEA[4:0]) read 0 whatever is written. The bytes 0xEC and 0xED also read 0.
- R8: On commit, lanes_o takes the staged lane count (0xE3[4:0]) or LANE_MAX, whichever is smaller. A lower value passes unchanged.
- R9: On commit, res_o takes the staged resolution (0xE7[4:0]) or RES_MAX, whichever is smaller.
- R10: Subclass (0xE8[7:5]) code 001 is unsupported. A commit that carries it leaves subcls_o unchanged. Codes 000 and 010 are taken as written.
- R11: The frames-per-multiframe field (0xE5[4:0]) commits every value from 0 to 31 unchanged onto frames_o.
- R12: Field positions: device id 0xE0[7:0], bank id 0xE1[3:0], lane id 0xE2[4:0], scramble enable 0xE3[7] (1 = on), octets per frame 0xE4[7:0], converters 0xE6[7:0], bits per sample 0xE8[4:0], revision 0xE9[7:5] (000 = A, 001 = B), samples per frame 0xE9[4:0], reserved byte 0xEB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data (staged bytes, start bit) |
| xmit_hold_o | output | 1 | Holds transmitter and clock multiplier in reset |
| cfg_upd_o | output | 1 | One-cycle pulse when the configuration is applied |
| dev_id_o | output | 8 | Active device id |
| bank_id_o | output | 4 | Active bank id |
| lane_id_o | output | 5 | Active lane id |
| scr_en_o | output | 1 | Active scramble enable |
| lanes_o | output | 5 | Active lane count code |
| octets_o | output | 8 | Active octets per frame |
| frames_o | output | 5 | Active frames per multiframe |
| conv_o | output | 8 | Active converter count |
| res_o | output | 5 | Active resolution |
| nbits_o | output | 5 | Active bits per sample |
| subcls_o | output | 3 | Active subclass code |
| ver_o | output | 3 | Active revision code |
| spf_o | output | 5 | Active samples per frame |
| rsvd_o | output | 8 | Active reserved byte |

## Verification
Each write is registered once. The hold output and the readback of a staged byte change on the first edge after the strobe. The active outputs and the update pulse change on the first edge after a commit write, and the pulse is gone one edge later. Reads are combinational and settle in the same cycle the address is set. The driver returns just after the edge that captured the write, queues the values due at that point, and the monitor compares them at the following falling edge. This places every check inside the cycle in which the result is due, before the next stimulus.

// File: rtl/link_cfg_pkg.sv
package link_cfg_pkg;
  localparam logic [7:0] START_ADDR  = 8'hDF;
  localparam logic [7:0] PARAM_BASE  = 8'hE0;
  localparam logic [7:0] COMMIT_ADDR = 8'hEE;
  localparam int unsigned NREG = 14;
  localparam logic [7:0] PARAM_LAST = PARAM_BASE + 8'(NREG - 1);

  // writable bits per staged byte; fixed-zero fields are masked out
  function automatic logic [7:0] reg_mask(input int unsigned idx);
    case (idx)
      0:  return 8'hFF;
      1:  return 8'h0F;
      2:  return 8'h1F;
      3:  return 8'h9F;
      4:  return 8'hFF;
      5:  return 8'h1F;
      6:  return 8'hFF;
      7:  return 8'h1F;
      8:  return 8'hFF;
      9:  return 8'hFF;
      11: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // maximum-capability reset values
  function automatic logic [7:0] reg_default(input int unsigned idx,
                                             input logic [4:0] lane_max,
                                             input logic [4:0] res_max);
    case (idx)
      3: return {3'b000, lane_max};
      4: return 8'h01;
      5: return 8'h0F;
      6: return 8'h01;
      7: return {3'b000, res_max};
      8: return {3'b000, 5'd15};
      9: return {3'b001, 5'd0};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/lcb_seq.sv
module lcb_seq
  import link_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic       wr_bit0_i,
  output logic       open_o,
  output logic       commit_o,
  output logic       stage_we_o,
  output logic [7:0] stage_idx_o,
  output logic       upd_o
);
  logic open_q, upd_q, start_wr, commit_wr, in_param;

  assign in_param  = (wr_addr_i >= PARAM_BASE) && (wr_addr_i <= PARAM_LAST);
  assign start_wr  = wr_en_i && (wr_addr_i == START_ADDR) && wr_bit0_i;
  assign commit_wr = wr_en_i && (wr_addr_i == COMMIT_ADDR) && wr_bit0_i;

  assign commit_o    = commit_wr && open_q;
  assign stage_we_o  = wr_en_i && in_param && open_q;
  assign stage_idx_o = wr_addr_i - PARAM_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_o;
      if (commit_o)      open_q <= 1'b0;
      else if (start_wr) open_q <= 1'b1;
    end
  end

  assign open_o = open_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/lcb_stage.sv
module lcb_stage
  import link_cfg_pkg::*;
#(
  parameter logic [4:0] LANE_MAX = 5'd3,
  parameter logic [4:0] RES_MAX  = 5'd13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           idx_i,
  input  logic [7:0]           wdata_i,
  output logic [NREG-1:0][7:0] stage_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam logic [7:0] MASK = reg_mask(i);
    localparam logic [7:0] DFLT = reg_default(i, LANE_MAX, RES_MAX);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= DFLT;
      else if (we_i && idx_i == 8'(i))   q <= wdata_i & MASK;
    end
    assign stage_o[i] = q;
  end
endmodule

// File: rtl/lcb_active.sv
module lcb_active
  import link_cfg_pkg::*;
#(
  parameter logic [4:0] LANE_MAX = 5'd3,
  parameter logic [4:0] RES_MAX  = 5'd13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NREG-1:0][7:0] stage_i,
  output logic [7:0]           dev_id_o,
  output logic [3:0]           bank_id_o,
  output logic [4:0]           lane_id_o,
  output logic                 scr_en_o,
  output logic [4:0]           lanes_o,
  output logic [7:0]           octets_o,
  output logic [4:0]           frames_o,
  output logic [7:0]           conv_o,
  output logic [4:0]           res_o,
  output logic [4:0]           nbits_o,
  output logic [2:0]           subcls_o,
  output logic [2:0]           ver_o,
  output logic [4:0]           spf_o,
  output logic [7:0]           rsvd_o
);
  localparam logic [7:0] D3 = reg_default(3, LANE_MAX, RES_MAX);
  localparam logic [7:0] D4 = reg_default(4, LANE_MAX, RES_MAX);
  localparam logic [7:0] D5 = reg_default(5, LANE_MAX, RES_MAX);
  localparam logic [7:0] D6 = reg_default(6, LANE_MAX, RES_MAX);
  localparam logic [7:0] D7 = reg_default(7, LANE_MAX, RES_MAX);
  localparam logic [7:0] D8 = reg_default(8, LANE_MAX, RES_MAX);
  localparam logic [7:0] D9 = reg_default(9, LANE_MAX, RES_MAX);
  localparam logic [2:0] SUBCLS_BAD = 3'b001;

  logic [4:0] lanes_lim, res_lim;
  logic [2:0] subcls_nxt;
  logic       unused_stage;

  // downgrade only: clamp to speed-grade ceiling
  assign lanes_lim  = (stage_i[3][4:0] > LANE_MAX) ? LANE_MAX : stage_i[3][4:0];
  assign res_lim    = (stage_i[7][4:0] > RES_MAX)  ? RES_MAX  : stage_i[7][4:0];
  assign subcls_nxt = (stage_i[8][7:5] == SUBCLS_BAD) ? subcls_o : stage_i[8][7:5];
  assign unused_stage = ^{stage_i[1][7:4], stage_i[2][7:5], stage_i[3][6:5],
                          stage_i[5][7:5], stage_i[7][7:5], stage_i[10],
                          stage_i[12], stage_i[13]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_id_o  <= '0;
      bank_id_o <= '0;
      lane_id_o <= '0;
      scr_en_o  <= D3[7];
      lanes_o   <= D3[4:0];
      octets_o  <= D4;
      frames_o  <= D5[4:0];
      conv_o    <= D6;
      res_o     <= D7[4:0];
      nbits_o   <= D8[4:0];
      subcls_o  <= D8[7:5];
      ver_o     <= D9[7:5];
      spf_o     <= D9[4:0];
      rsvd_o    <= '0;
    end else if (load_i) begin
      dev_id_o  <= stage_i[0];
      bank_id_o <= stage_i[1][3:0];
      lane_id_o <= stage_i[2][4:0];
      scr_en_o  <= stage_i[3][7];
      lanes_o   <= lanes_lim;
      octets_o  <= stage_i[4];
      frames_o  <= stage_i[5][4:0];
      conv_o    <= stage_i[6];
      res_o     <= res_lim;
      nbits_o   <= stage_i[8][4:0];
      subcls_o  <= subcls_nxt;
      ver_o     <= stage_i[9][7:5];
      spf_o     <= stage_i[9][4:0];
      rsvd_o    <= stage_i[11];
    end
  end
endmodule

// File: rtl/link_cfg_bank.sv
module link_cfg_bank
  import link_cfg_pkg::*;
#(
  parameter logic [4:0] LANE_MAX = 5'd3,
  parameter logic [4:0] RES_MAX  = 5'd13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       xmit_hold_o,
  output logic       cfg_upd_o,
  output logic [7:0] dev_id_o,
  output logic [3:0] bank_id_o,
  output logic [4:0] lane_id_o,
  output logic       scr_en_o,
  output logic [4:0] lanes_o,
  output logic [7:0] octets_o,
  output logic [4:0] frames_o,
  output logic [7:0] conv_o,
  output logic [4:0] res_o,
  output logic [4:0] nbits_o,
  output logic [2:0] subcls_o,
  output logic [2:0] ver_o,
  output logic [4:0] spf_o,
  output logic [7:0] rsvd_o
);
  logic                 open, commit, stage_we;
  logic [7:0]           stage_idx, rd_idx;
  logic [NREG-1:0][7:0] stage;

  lcb_seq u_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i,
    .wr_bit0_i   (wr_data_i[0]),
    .open_o      (open),
    .commit_o    (commit),
    .stage_we_o  (stage_we),
    .stage_idx_o (stage_idx),
    .upd_o       (cfg_upd_o)
  );

  lcb_stage #(.LANE_MAX(LANE_MAX), .RES_MAX(RES_MAX)) u_stage (
    .clk_i, .rst_ni,
    .we_i    (stage_we),
    .idx_i   (stage_idx),
    .wdata_i (wr_data_i),
    .stage_o (stage)
  );

  lcb_active #(.LANE_MAX(LANE_MAX), .RES_MAX(RES_MAX)) u_active (
    .clk_i, .rst_ni,
    .load_i  (commit),
    .stage_i (stage),
    .dev_id_o, .bank_id_o, .lane_id_o, .scr_en_o, .lanes_o, .octets_o,
    .frames_o, .conv_o, .res_o, .nbits_o, .subcls_o, .ver_o, .spf_o, .rsvd_o
  );

  assign xmit_hold_o = open;
  assign rd_idx = rd_addr_i - PARAM_BASE;

  // commit bit applies in one cycle, so it always reads back 0
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == START_ADDR)
      rd_data_o = {7'b0, open};
    else if (rd_addr_i >= PARAM_BASE && rd_addr_i <= PARAM_LAST)
      rd_data_o = stage[rd_idx[3:0]];
  end
endmodule

// File: rtl/lcb_chk.sv
module lcb_chk #(
  parameter logic [4:0] LANE_MAX = 5'd3,
  parameter logic [4:0] RES_MAX  = 5'd13
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       xmit_hold_o,
  input logic       cfg_upd_o,
  input logic [4:0] lanes_o,
  input logic [4:0] res_o,
  input logic [2:0] subcls_o,
  input logic [7:0] dev_id_o
);
  // R2
  hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xmit_hold_o) |-> $past(wr_en_i && wr_addr_i == 8'hDF && wr_data_i[0]));
  // R4
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_upd_o |=> !cfg_upd_o);
  // R4
  upd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_upd_o |-> (!xmit_hold_o && $past(xmit_hold_o)));
  // R3
  active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_upd_o |-> ($stable(lanes_o) && $stable(res_o) && $stable(dev_id_o)));
  // R8
  lanes_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lanes_o <= LANE_MAX);
  // R9
  res_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o <= RES_MAX);
  // R10
  subcls_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subcls_o != 3'b001);
endmodule

bind link_cfg_bank lcb_chk #(.LANE_MAX(LANE_MAX), .RES_MAX(RES_MAX)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .xmit_hold_o,
  .cfg_upd_o, .lanes_o, .res_o, .subcls_o, .dev_id_o
);

// File: tb/tb_link_cfg_bank.sv
`timescale 1ns/1ps
module tb_link_cfg_bank;
  localparam logic [4:0] LMAX = 5'd3;
  localparam logic [4:0] NMAX = 5'd13;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  logic hold, upd, scr;
  logic [7:0] dev, octets, conv, rsvd;
  logic [3:0] bank;
  logic [4:0] lane_id, lanes, frames, res, nbits, spf;
  logic [2:0] subcls, ver;

  always #2.5 clk = ~clk;

  link_cfg_bank #(.LANE_MAX(LMAX), .RES_MAX(NMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .xmit_hold_o(hold), .cfg_upd_o(upd), .dev_id_o(dev), .bank_id_o(bank),
    .lane_id_o(lane_id), .scr_en_o(scr), .lanes_o(lanes), .octets_o(octets),
    .frames_o(frames), .conv_o(conv), .res_o(res), .nbits_o(nbits),
    .subcls_o(subcls), .ver_o(ver), .spf_o(spf), .rsvd_o(rsvd)
  );

  typedef enum int {S_RD, S_HOLD, S_UPD, S_LANES, S_RES, S_SUB, S_FRM, S_DEV, S_SCR} sel_e;
  typedef struct { sel_e sel; int exp; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int sample(sel_e s);
    case (s)
      S_RD:    return int'(rd_data);
      S_HOLD:  return int'(hold);
      S_UPD:   return int'(upd);
      S_LANES: return int'(lanes);
      S_RES:   return int'(res);
      S_SUB:   return int'(subcls);
      S_FRM:   return int'(frames);
      S_DEV:   return int'(dev);
      default: return int'(scr);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sample(it.sel) !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%s actual=%0d expected=%0d", it.req, it.sel.name(),
                 sample(it.sel), it.exp);
      end
    end
  end

  task automatic push(sel_e s, int e, string r);
    item_t it;
    it.sel = s; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic flush();
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, int e, string r);
    rd_addr = a;
    push(S_RD, e, r);
    flush();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    push(S_HOLD, 0, "R1"); push(S_UPD, 0, "R1");
    push(S_LANES, LMAX, "R1"); push(S_RES, NMAX, "R1");
    push(S_SUB, 0, "R1"); push(S_FRM, 15, "R1"); push(S_DEV, 0, "R1");
    flush();
    rd_chk(8'hE3, LMAX, "R1");
    rd_chk(8'hE7, NMAX, "R1");

    // R6 param write with no open update
    wr(8'hE4, 8'h55);
    rd_chk(8'hE4, 8'h01, "R6");

    // R5 commit with no open update
    wr(8'hEE, 8'h01);
    push(S_UPD, 0, "R5"); push(S_HOLD, 0, "R5"); push(S_LANES, LMAX, "R5");
    flush();

    // R2 open
    wr(8'hDF, 8'h01);
    push(S_HOLD, 1, "R2"); flush();
    rd_chk(8'hDF, 1, "R2");

    // R3 staged writes, R7 fixed fields, R12 layout
    wr(8'hE0, 8'hA5);
    wr(8'hE3, 8'h9F);
    wr(8'hE5, 8'h1F);
    wr(8'hE7, 8'hFF);
    wr(8'hE8, 8'h21);
    wr(8'hEA, 8'hFF);
    wr(8'hEC, 8'hFF);
    rd_chk(8'hE3, 8'h9F, "R3");
    rd_chk(8'hE0, 8'hA5, "R3");
    rd_chk(8'hE7, 8'h1F, "R7");
    rd_chk(8'hEA, 8'h00, "R7");
    rd_chk(8'hEC, 8'h00, "R7");
    push(S_LANES, LMAX, "R3"); push(S_DEV, 0, "R3"); push(S_HOLD, 1, "R3");
    flush();

    // R4 commit, R8/R9 clamp, R10 refuse 001, R11 K=31, R12 fields
    wr(8'hEE, 8'h01);
    push(S_UPD, 1, "R4"); push(S_HOLD, 0, "R4");
    push(S_DEV, 8'hA5, "R12"); push(S_SCR, 1, "R12");
    push(S_LANES, LMAX, "R8"); push(S_RES, NMAX, "R9");
    push(S_SUB, 0, "R10"); push(S_FRM, 31, "R11");
    flush();
    @(posedge clk); #1;
    push(S_UPD, 0, "R4"); flush();
    rd_chk(8'hDF, 0, "R4");
    rd_chk(8'hEE, 0, "R4");

    // downgrade path: R8, R9, R10, R11
    wr(8'hDF, 8'h01);
    wr(8'hE3, 8'h01);
    wr(8'hE7, 8'h08);
    wr(8'hE8, 8'h40);
    wr(8'hE5, 8'h00);
    wr(8'hEE, 8'h01);
    push(S_UPD, 1, "R4");
    push(S_LANES, 1, "R8"); push(S_RES, 8, "R9");
    push(S_SUB, 2, "R10"); push(S_FRM, 0, "R11"); push(S_SCR, 0, "R12");
    flush();

    // R10 code 001 after a 010 keeps 010
    wr(8'hDF, 8'h01);
    wr(8'hE8, 8'h2F);
    wr(8'hEE, 8'h01);
    push(S_SUB, 2, "R10"); flush();

    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule